// File: doc/BRIEF.md
# NAND Command Issue Sequencer

This block sits between a flash translation layer and a NAND controller core. It accepts one host-level request at a time. A request is an opcode, an optional column, an optional page address, a chip select and the current device geometry. From these the block builds the controller's primary command word, its secondary (confirm and ECC-control) word, the two address registers and the transfer length. It then fires a one-cycle launch strobe and waits for the core to report completion. A microsecond tick bounds the wait.

Program and erase are two-phase on the NAND side. The first half of each pair (data-input setup, erase setup) is only recorded, together with its addresses. The launch happens when the matching confirm opcode arrives, and that opcode goes out in the secondary word. Reads on large-page devices get their confirm opcode appended automatically. A spare-area read on such devices is turned into a normal page read at an offset column. While a command is in flight the block holds further requests off through its ready output.

Top module: `nand_cmd_seq`

## Requirements
- R1: A launched primary word has bit 31 set, the effective opcode in bits 7:0 and the chip select in bit 19 (0 selects the first device, 1 the second).
- R2: Primary bit 26 (read) is set for opcodes 0x90, 0x70, 0x00, 0x01, 0x50 and 0x05. Bit 25 (write) is set only for 0x80. No other opcode sets either bit.
- R3: The address-cycle count n is built as follows: 2 for a column, plus 2 for a page, plus 1 more when the device byte count exceeds the page size times 65536. A page with no column counts 2 plus that extra byte. When n is non-zero, bits 30:27 carry (n-1) OR 8; otherwise they are zero.
- R4: With a column, address register 1 takes the column and register 2 takes the whole page. With a page but no column, register 1 takes the low 16 page bits and register 2 the rest. A one-cycle addr_load marks either case.
- R5: Opcodes 0x90 and 0x70 always use exactly one address cycle and a transfer length of 4.
- R6: On pages above 512 bytes, opcode 0x50 is sent as 0x00 with the page size added to the column. For reads and for 0x80, the length is page size plus spare size minus column.
- R7: Opcodes 0x80 and 0x60 load the address registers and are held back: no launch occurs, busy stays low and ready stays high.
- R8: Opcode 0x10 or 0xD0 following a held first half launches the stored primary word and length. Its secondary word is the base value, OR the ECC-generate flag in bit 30, OR 0x100, OR the opcode.
- R9: At launch the secondary word is base|0x100|0xE0 for 0x05, and base|0x100|0x30 for 0x00 on pages above 512 bytes. For every other non-confirm command it is zero.
- R10: A launched command completes on cmp_flag. For read-direction commands while DMA is enabled it completes on dma_flag only. Completion returns to idle with a one-cycle done_ack.
- R11: If POLL_LIMIT ticks pass without completion, the command ends with done_ack and a sticky timeout flag. The next accepted request clears the flag.
- R12: Whenever a command ends, the secondary word is reloaded as the base value with bit 30 cleared.
- R13: Busy is high from acceptance of a launched command until its end. Ready is its complement, and a request presented while busy waits unaccepted.
- R14: A confirm opcode with no held first half is launched alone: no address or direction bits, and a zero secondary word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_opcode | input | 8 | NAND opcode |
| req_has_col | input | 1 | Column supplied |
| req_col | input | GEOM_W | Column byte offset |
| req_has_page | input | 1 | Page address supplied |
| req_page | input | PAGE_W | Page address |
| req_cs | input | 1 | Chip select |
| req_ecc_gen | input | 1 | Request ECC generation on a confirm opcode |
| cfg_page_bytes | input | GEOM_W | Page data size |
| cfg_spare_bytes | input | GEOM_W | Spare area size |
| cfg_dev_bytes | input | DEV_W | Device size in bytes |
| cfg_ctl2 | input | 32 | Base secondary word |
| cfg_use_dma | input | 1 | Reads complete on the DMA flag |
| us_tick | input | 1 | One-microsecond tick |
| cmp_flag | input | 1 | Command-done flag from the core |
| dma_flag | input | 1 | DMA-done flag from the core |
| prim_word | output | 32 | Primary command word |
| sec_word | output | 32 | Secondary command word |
| sec_load | output | 1 | Secondary word updated this cycle |
| addr1 | output | GEOM_W | First address register |
| addr2 | output | PAGE_W | Second address register |
| addr_load | output | 1 | Address registers updated this cycle |
| data_len | output | GEOM_W+1 | Transfer length |
| launch | output | 1 | Launch strobe |
| done_ack | output | 1 | Completion flag clear strobe |
| busy | output | 1 | Command in flight |
| timeout | output | 1 | Sticky timeout flag |

## Verification
Some properties are checked on every cycle. Every launch carries the valid bit. No launch is read and write at once. A non-zero count field always carries its marker bit. Nothing launches while busy, and a held first half never launches or raises busy. Every ending reloads the secondary word with ECC generation off. The poll counter never passes its limit. The exact word encodings, the address split, the spare-read rewrite and the lengths can only be shown by the directed scenarios. So can the pairing of halves, the choice of completion flag, back-pressure and timeout expiry.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam logic [7:0] OP_READ0    = 8'h00;
  localparam logic [7:0] OP_READ1    = 8'h01;
  localparam logic [7:0] OP_RNDOUT   = 8'h05;
  localparam logic [7:0] OP_PAGEPROG = 8'h10;
  localparam logic [7:0] OP_READSTRT = 8'h30;
  localparam logic [7:0] OP_READOOB  = 8'h50;
  localparam logic [7:0] OP_ERASE1   = 8'h60;
  localparam logic [7:0] OP_STATUS   = 8'h70;
  localparam logic [7:0] OP_SEQIN    = 8'h80;
  localparam logic [7:0] OP_READID   = 8'h90;
  localparam logic [7:0] OP_ERASE2   = 8'hD0;
  localparam logic [7:0] OP_RNDOSTRT = 8'hE0;

  localparam int PW_VALID  = 31;
  localparam int PW_CS     = 19;
  localparam int PW_RD     = 26;
  localparam int PW_WR     = 25;
  localparam int SW_ECC    = 30;
  localparam logic [31:0] SW_ISSUE = 32'h0000_0100;

  typedef enum logic [1:0] {
    CLS_PLAIN  = 2'd0,
    CLS_FIRST  = 2'd1,
    CLS_SECOND = 2'd2
  } nseq_class_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } nseq_state_e;

endpackage

// File: rtl/nand_seq_decode.sv
module nand_seq_decode
  import nand_seq_pkg::*;
#(
  parameter int GEOM_W = 16,
  parameter int PAGE_W = 24,
  parameter int DEV_W  = 40
) (
  input  logic [7:0]        op_i,
  input  logic              has_col_i,
  input  logic [GEOM_W-1:0] col_i,
  input  logic              has_page_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              cs_i,
  input  logic [GEOM_W-1:0] page_bytes_i,
  input  logic [GEOM_W-1:0] spare_bytes_i,
  input  logic [DEV_W-1:0]  dev_bytes_i,
  input  logic [31:0]       ctl2_i,
  output logic [31:0]       prim_o,
  output logic [31:0]       sec_o,
  output logic [GEOM_W-1:0] addr1_o,
  output logic [PAGE_W-1:0] addr2_o,
  output logic              addr_used_o,
  output logic [GEOM_W:0]   dlen_o,
  output nseq_class_e       cls_o
);

  localparam int DLEN_W = GEOM_W + 1;

  logic [7:0]        eff_op;
  logic [GEOM_W-1:0] eff_col;
  logic              col_present;
  logic              large_page;
  logic              extra_cycle;
  logic              rewrite_oob;
  logic              is_rd;
  logic              is_wr;
  logic              is_short;
  logic [2:0]        n_cyc;
  logic [DEV_W-1:0]  page_span;

  always_comb begin
    page_span   = {{(DEV_W-GEOM_W){1'b0}}, page_bytes_i} << 16;
    extra_cycle = dev_bytes_i > page_span;
    large_page  = page_bytes_i > GEOM_W'(512);
    rewrite_oob = (op_i == OP_READOOB) && large_page;
    eff_op      = rewrite_oob ? OP_READ0 : op_i;
    eff_col     = has_col_i ? col_i : '0;
    if (rewrite_oob) eff_col = eff_col + page_bytes_i;
    col_present = has_col_i || rewrite_oob;

    is_short = (eff_op == OP_READID) || (eff_op == OP_STATUS);
    is_rd    = is_short || (eff_op == OP_READ0) || (eff_op == OP_READ1) ||
               (eff_op == OP_READOOB) || (eff_op == OP_RNDOUT);
    is_wr    = (eff_op == OP_SEQIN);

    n_cyc = 3'd0;
    if (col_present) begin
      n_cyc = 3'd2;
      if (has_page_i) n_cyc = extra_cycle ? 3'd5 : 3'd4;
    end else if (has_page_i) begin
      n_cyc = extra_cycle ? 3'd3 : 3'd2;
    end
    if (is_short) n_cyc = 3'd1;

    addr_used_o = col_present || has_page_i;
    if (col_present) begin
      addr1_o = eff_col;
      addr2_o = page_i;
    end else begin
      addr1_o = page_i[GEOM_W-1:0];
      addr2_o = page_i >> GEOM_W;
    end

    prim_o           = '0;
    prim_o[PW_VALID] = 1'b1;
    prim_o[7:0]      = eff_op;
    prim_o[PW_CS]    = cs_i;
    prim_o[PW_RD]    = is_rd;
    prim_o[PW_WR]    = is_wr;
    if (n_cyc != 3'd0) prim_o[30:27] = {1'b1, n_cyc - 3'd1};

    if (is_short)
      dlen_o = DLEN_W'(4);
    else if (is_rd || is_wr)
      dlen_o = {1'b0, page_bytes_i} + {1'b0, spare_bytes_i} - {1'b0, eff_col};
    else
      dlen_o = '0;

    if (eff_op == OP_RNDOUT)
      sec_o = ctl2_i | SW_ISSUE | {24'd0, OP_RNDOSTRT};
    else if ((eff_op == OP_READ0) && large_page)
      sec_o = ctl2_i | SW_ISSUE | {24'd0, OP_READSTRT};
    else
      sec_o = '0;

    if ((op_i == OP_SEQIN) || (op_i == OP_ERASE1))
      cls_o = CLS_FIRST;
    else if ((op_i == OP_PAGEPROG) || (op_i == OP_ERASE2))
      cls_o = CLS_SECOND;
    else
      cls_o = CLS_PLAIN;
  end

endmodule

// File: rtl/nand_seq_pair.sv
module nand_seq_pair #(
  parameter int GEOM_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            store_i,
  input  logic            consume_i,
  input  logic [31:0]     prim_i,
  input  logic [GEOM_W:0] dlen_i,
  output logic            pending_o,
  output logic [31:0]     prim_o,
  output logic [GEOM_W:0] dlen_o
);

  logic            pend_q, pend_d;
  logic [31:0]     prim_q;
  logic [GEOM_W:0] dlen_q;

  always_comb begin
    pend_d = pend_q;
    if (store_i)        pend_d = 1'b1;
    else if (consume_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      prim_q <= '0;
      dlen_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (store_i) begin
        prim_q <= prim_i;
        dlen_q <= dlen_i;
      end
    end
  end

  assign pending_o = pend_q;
  assign prim_o    = prim_q;
  assign dlen_o    = dlen_q;

  // R8: a first half and its confirm never share one acceptance
  a_r8_store_consume_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_i && consume_i));

  // R8: a consumed pair leaves nothing held
  a_r8_consume_releases: assert property (@(posedge clk) disable iff (!rst_n)
    consume_i |=> !pend_q);

endmodule

// File: rtl/nand_seq_wait.sv
module nand_seq_wait #(
  parameter int POLL_LIMIT = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic active_i,
  input  logic tick_i,
  input  logic hit_i,
  output logic finish_o,
  output logic expired_o
);

  localparam int CNT_W = $clog2(POLL_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(POLL_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             at_last;

  always_comb begin
    at_last   = (cnt_q == LAST);
    expired_o = active_i && !hit_i && tick_i && at_last;
    finish_o  = active_i && (hit_i || expired_o);
    cnt_en    = start_i || (active_i && tick_i && !hit_i && !at_last);
    cnt_d     = start_i ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R11: the poll counter stays inside its window
  a_r11_poll_window: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int GEOM_W     = 16,
  parameter int PAGE_W     = 24,
  parameter int DEV_W      = 40,
  parameter int POLL_LIMIT = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_opcode,
  input  logic              req_has_col,
  input  logic [GEOM_W-1:0] req_col,
  input  logic              req_has_page,
  input  logic [PAGE_W-1:0] req_page,
  input  logic              req_cs,
  input  logic              req_ecc_gen,
  input  logic [GEOM_W-1:0] cfg_page_bytes,
  input  logic [GEOM_W-1:0] cfg_spare_bytes,
  input  logic [DEV_W-1:0]  cfg_dev_bytes,
  input  logic [31:0]       cfg_ctl2,
  input  logic              cfg_use_dma,
  input  logic              us_tick,
  input  logic              cmp_flag,
  input  logic              dma_flag,
  output logic [31:0]       prim_word,
  output logic [31:0]       sec_word,
  output logic              sec_load,
  output logic [GEOM_W-1:0] addr1,
  output logic [PAGE_W-1:0] addr2,
  output logic              addr_load,
  output logic [GEOM_W:0]   data_len,
  output logic              launch,
  output logic              done_ack,
  output logic              busy,
  output logic              timeout
);

  nseq_state_e       state_q, state_d;
  logic [31:0]       prim_q, prim_d, sec_q, sec_d;
  logic [GEOM_W-1:0] addr1_q;
  logic [PAGE_W-1:0] addr2_q;
  logic [GEOM_W:0]   dlen_q, dlen_d;
  logic              launch_q, launch_d;
  logic              sec_ld_q, sec_ld_d;
  logic              addr_ld_q, addr_ld_d;
  logic              ack_q, ack_d;
  logic              tmo_q, tmo_d;
  logic              rd_q, rd_d;
  logic              cmd_en, addr_en;

  logic [31:0]       dec_prim, dec_sec;
  logic [GEOM_W-1:0] dec_addr1;
  logic [PAGE_W-1:0] dec_addr2;
  logic              dec_addr_used;
  logic [GEOM_W:0]   dec_dlen;
  nseq_class_e       dec_cls;

  logic              accept, store, consume, start;
  logic              pend;
  logic [31:0]       held_prim;
  logic [GEOM_W:0]   held_dlen;
  logic              hit, finish, expired;

  nand_seq_decode #(.GEOM_W(GEOM_W), .PAGE_W(PAGE_W), .DEV_W(DEV_W)) u_decode (
    .op_i          (req_opcode),
    .has_col_i     (req_has_col),
    .col_i         (req_col),
    .has_page_i    (req_has_page),
    .page_i        (req_page),
    .cs_i          (req_cs),
    .page_bytes_i  (cfg_page_bytes),
    .spare_bytes_i (cfg_spare_bytes),
    .dev_bytes_i   (cfg_dev_bytes),
    .ctl2_i        (cfg_ctl2),
    .prim_o        (dec_prim),
    .sec_o         (dec_sec),
    .addr1_o       (dec_addr1),
    .addr2_o       (dec_addr2),
    .addr_used_o   (dec_addr_used),
    .dlen_o        (dec_dlen),
    .cls_o         (dec_cls)
  );

  assign accept  = req_valid && (state_q == ST_IDLE);
  assign store   = accept && (dec_cls == CLS_FIRST);
  assign consume = accept && (dec_cls == CLS_SECOND) && pend;
  assign start   = accept && (dec_cls != CLS_FIRST);

  nand_seq_pair #(.GEOM_W(GEOM_W)) u_pair (
    .clk       (clk),
    .rst_n     (rst_n),
    .store_i   (store),
    .consume_i (consume),
    .prim_i    (dec_prim),
    .dlen_i    (dec_dlen),
    .pending_o (pend),
    .prim_o    (held_prim),
    .dlen_o    (held_dlen)
  );

  assign hit = (rd_q && cfg_use_dma) ? dma_flag : cmp_flag;

  nand_seq_wait #(.POLL_LIMIT(POLL_LIMIT)) u_wait (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .active_i  (state_q == ST_WAIT),
    .tick_i    (us_tick),
    .hit_i     (hit),
    .finish_o  (finish),
    .expired_o (expired)
  );

  // next-state process
  always_comb begin
    state_d   = state_q;
    prim_d    = prim_q;
    sec_d     = sec_q;
    dlen_d    = dlen_q;
    rd_d      = rd_q;
    tmo_d     = tmo_q;
    launch_d  = 1'b0;
    sec_ld_d  = 1'b0;
    addr_ld_d = 1'b0;
    ack_d     = 1'b0;
    cmd_en    = 1'b0;
    addr_en   = 1'b0;

    if (accept) begin
      tmo_d     = 1'b0;
      addr_en   = dec_addr_used;
      addr_ld_d = dec_addr_used;
      sec_ld_d  = 1'b1;
      if (dec_cls == CLS_FIRST) begin
        sec_d = '0;
      end else begin
        cmd_en   = 1'b1;
        launch_d = 1'b1;
        state_d  = ST_WAIT;
        if (consume) begin
          prim_d = held_prim;
          dlen_d = held_dlen;
          sec_d  = cfg_ctl2 | (32'(req_ecc_gen) << SW_ECC) | SW_ISSUE | {24'd0, req_opcode};
        end else begin
          prim_d = dec_prim;
          dlen_d = dec_dlen;
          sec_d  = dec_sec;
        end
        rd_d = prim_d[PW_RD];
      end
    end else if ((state_q == ST_WAIT) && finish) begin
      state_d  = ST_IDLE;
      ack_d    = 1'b1;
      sec_ld_d = 1'b1;
      sec_d    = cfg_ctl2 & ~(32'd1 << SW_ECC);
      tmo_d    = expired;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      prim_q    <= '0;
      sec_q     <= '0;
      addr1_q   <= '0;
      addr2_q   <= '0;
      dlen_q    <= '0;
      rd_q      <= 1'b0;
      tmo_q     <= 1'b0;
      launch_q  <= 1'b0;
      sec_ld_q  <= 1'b0;
      addr_ld_q <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      tmo_q     <= tmo_d;
      launch_q  <= launch_d;
      sec_ld_q  <= sec_ld_d;
      addr_ld_q <= addr_ld_d;
      ack_q     <= ack_d;
      if (sec_ld_d) sec_q <= sec_d;
      if (cmd_en) begin
        prim_q <= prim_d;
        dlen_q <= dlen_d;
        rd_q   <= rd_d;
      end
      if (addr_en) begin
        addr1_q <= dec_addr1;
        addr2_q <= dec_addr2;
      end
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign busy      = (state_q == ST_WAIT);
  assign prim_word = prim_q;
  assign sec_word  = sec_q;
  assign sec_load  = sec_ld_q;
  assign addr1     = addr1_q;
  assign addr2     = addr2_q;
  assign addr_load = addr_ld_q;
  assign data_len  = dlen_q;
  assign launch    = launch_q;
  assign done_ack  = ack_q;
  assign timeout   = tmo_q;

  // R1: every launched word is marked valid
  a_r1_launch_valid: assert property (@(posedge clk) disable iff (!rst_n)
    launch_q |-> prim_word[PW_VALID]);

  // R2: a launched word never asks for both directions
  a_r2_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    launch_q |-> !(prim_word[PW_RD] && prim_word[PW_WR]));

  // R3: a non-zero cycle count always carries its marker bit
  a_r3_count_marker: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_q && (prim_word[29:27] != 3'd0)) |-> prim_word[30]);

  // R7: a held first half neither launches nor raises busy
  a_r7_first_held: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> (!launch_q && !busy));

  // R13: nothing launches out of the busy state
  a_r13_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !launch_q);

  // R10: an acknowledged command leaves the block idle and ready
  a_r10_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_ack |-> (!busy && req_ready));

  // R12: every ending reloads the secondary word with ECC generation off
  a_r12_restore: assert property (@(posedge clk) disable iff (!rst_n)
    done_ack |-> (sec_load && !sec_word[SW_ECC]));

endmodule

// File: tb/test_nand_cmd_seq.sv
`timescale 1ns/1ps
module test_nand_cmd_seq;

  localparam int GEOM_W = 16;
  localparam int PAGE_W = 24;
  localparam int DEV_W  = 40;
  localparam int LIMIT  = 20;
  localparam logic [31:0] BASE = 32'h2800_0000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_ready;
  logic [7:0]        req_opcode;
  logic              req_has_col, req_has_page, req_cs, req_ecc_gen;
  logic [GEOM_W-1:0] req_col;
  logic [PAGE_W-1:0] req_page;
  logic [GEOM_W-1:0] cfg_page_bytes, cfg_spare_bytes;
  logic [DEV_W-1:0]  cfg_dev_bytes;
  logic [31:0]       cfg_ctl2;
  logic              cfg_use_dma, us_tick, cmp_flag, dma_flag;
  logic [31:0]       prim_word, sec_word;
  logic              sec_load, addr_load, launch, done_ack, busy, timeout;
  logic [GEOM_W-1:0] addr1;
  logic [PAGE_W-1:0] addr2;
  logic [GEOM_W:0]   data_len;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  nand_cmd_seq #(.GEOM_W(GEOM_W), .PAGE_W(PAGE_W), .DEV_W(DEV_W), .POLL_LIMIT(LIMIT)) i_nand_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_opcode(req_opcode), .req_has_col(req_has_col), .req_col(req_col),
    .req_has_page(req_has_page), .req_page(req_page), .req_cs(req_cs),
    .req_ecc_gen(req_ecc_gen), .cfg_page_bytes(cfg_page_bytes),
    .cfg_spare_bytes(cfg_spare_bytes), .cfg_dev_bytes(cfg_dev_bytes),
    .cfg_ctl2(cfg_ctl2), .cfg_use_dma(cfg_use_dma), .us_tick(us_tick),
    .cmp_flag(cmp_flag), .dma_flag(dma_flag), .prim_word(prim_word),
    .sec_word(sec_word), .sec_load(sec_load), .addr1(addr1), .addr2(addr2),
    .addr_load(addr_load), .data_len(data_len), .launch(launch),
    .done_ack(done_ack), .busy(busy), .timeout(timeout)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic large_geom();
    cfg_page_bytes  = 16'd2048;
    cfg_spare_bytes = 16'd64;
    cfg_dev_bytes   = 40'h00_1000_0000;
  endtask

  // drive one request, return at the first negedge after it was taken
  task automatic issue(input logic [7:0] op, input logic hc, input logic [15:0] col,
                       input logic hp, input logic [23:0] pg, input logic cs, input logic ecc);
    @(negedge clk);
    req_opcode = op; req_has_col = hc; req_col = col;
    req_has_page = hp; req_page = pg; req_cs = cs; req_ecc_gen = ecc;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_cmp(input string tag);
    cmp_flag = 1'b1;
    @(negedge clk);
    cmp_flag = 1'b0;
    chk({tag, " R10 done_ack"}, 32'(done_ack), 32'd1);
    chk({tag, " R13 busy low"}, 32'(busy), 32'd0);
    chk({tag, " R12 sec restore"}, sec_word, BASE);
  endtask

  task automatic t_reset();
    chk("R13 reset busy", 32'(busy), 32'd0);
    chk("R13 reset ready", 32'(req_ready), 32'd1);
    chk("R1 reset launch", 32'(launch), 32'd0);
    chk("R11 reset timeout", 32'(timeout), 32'd0);
  endtask

  task automatic t_readid();
    issue(8'h90, 1'b1, 16'h0000, 1'b0, 24'h0, 1'b0, 1'b0);
    chk("R1 readid launch", 32'(launch), 32'd1);
    chk("R5 readid word", prim_word, 32'hC400_0090);
    chk("R5 readid len", 32'(data_len), 32'd4);
    chk("R9 readid sec zero", sec_word, 32'h0);
    chk("R13 readid busy", 32'(busy), 32'd1);
    finish_cmp("readid");
  endtask

  task automatic t_status_dma();
    cfg_use_dma = 1'b1;
    issue(8'h70, 1'b0, 16'h0, 1'b0, 24'h0, 1'b1, 1'b0);
    chk("R1 status cs word", prim_word, 32'hC408_0070);
    chk("R5 status len", 32'(data_len), 32'd4);
    cmp_flag = 1'b1;
    @(negedge clk);
    cmp_flag = 1'b0;
    @(negedge clk);
    chk("R10 read ignores cmp under dma", 32'(busy), 32'd1);
    dma_flag = 1'b1;
    @(negedge clk);
    dma_flag = 1'b0;
    chk("R10 dma completes read", 32'(done_ack), 32'd1);
    chk("R10 idle after dma", 32'(busy), 32'd0);
    cfg_use_dma = 1'b0;
  endtask

  task automatic t_read0_large();
    issue(8'h00, 1'b1, 16'h0010, 1'b1, 24'h012345, 1'b0, 1'b0);
    chk("R3 read0 five cycles", prim_word, 32'hE400_0000);
    chk("R4 read0 addr1 col", 32'(addr1), 32'h0010);
    chk("R4 read0 addr2 page", 32'(addr2), 32'h012345);
    chk("R4 read0 addr_load", 32'(addr_load), 32'd1);
    chk("R6 read0 len", 32'(data_len), 32'd2096);
    chk("R9 read0 readstart", sec_word, 32'h2800_0130);
    finish_cmp("read0");
  endtask

  task automatic t_readoob_large();
    issue(8'h50, 1'b1, 16'h0000, 1'b1, 24'h000005, 1'b0, 1'b0);
    chk("R6 oob rewritten", prim_word, 32'hE400_0000);
    chk("R6 oob column", 32'(addr1), 32'h0800);
    chk("R6 oob len", 32'(data_len), 32'd64);
    chk("R9 oob readstart", sec_word, 32'h2800_0130);
    finish_cmp("readoob");
  endtask

  task automatic t_small_page();
    cfg_page_bytes  = 16'd512;
    cfg_spare_bytes = 16'd16;
    cfg_dev_bytes   = 40'h00_0200_0000;
    issue(8'h50, 1'b1, 16'h0000, 1'b1, 24'h000007, 1'b0, 1'b0);
    chk("R3 R6 small oob kept", prim_word, 32'hDC00_0050);
    chk("R6 small oob len", 32'(data_len), 32'd528);
    chk("R9 small sec zero", sec_word, 32'h0);
    finish_cmp("small");
    large_geom();
  endtask

  task automatic t_erase_pair();
    issue(8'h60, 1'b0, 16'h0, 1'b1, 24'h03ABCD, 1'b1, 1'b0);
    chk("R7 erase1 no launch", 32'(launch), 32'd0);
    chk("R7 erase1 not busy", 32'(busy), 32'd0);
    chk("R7 erase1 ready", 32'(req_ready), 32'd1);
    chk("R4 page split low", 32'(addr1), 32'h0000_ABCD);
    chk("R4 page split high", 32'(addr2), 32'h0000_0003);
    issue(8'hD0, 1'b0, 16'h0, 1'b0, 24'h0, 1'b0, 1'b0);
    chk("R8 erase2 launch", 32'(launch), 32'd1);
    chk("R3 R8 stored word", prim_word, 32'hD008_0060);
    chk("R8 erase2 sec", sec_word, 32'h2800_01D0);
    finish_cmp("erase");
  endtask

  task automatic t_program_pair();
    issue(8'h80, 1'b1, 16'h0000, 1'b1, 24'h000020, 1'b0, 1'b0);
    chk("R7 seqin no launch", 32'(launch), 32'd0);
    chk("R7 seqin busy low", 32'(busy), 32'd0);
    issue(8'h10, 1'b0, 16'h0, 1'b0, 24'h0, 1'b1, 1'b1);
    chk("R2 R8 program word", prim_word, 32'hE200_0080);
    chk("R6 R8 program len", 32'(data_len), 32'd2112);
    chk("R8 program sec ecc", sec_word, 32'h6800_0110);
    finish_cmp("program");
  endtask

  task automatic t_backpressure();
    issue(8'h90, 1'b1, 16'h0, 1'b0, 24'h0, 1'b0, 1'b0);
    @(negedge clk);
    req_opcode = 8'h05; req_has_col = 1'b1; req_col = 16'h0040;
    req_has_page = 1'b0; req_page = 24'h0; req_cs = 1'b0; req_ecc_gen = 1'b0;
    req_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R13 held off ready", 32'(req_ready), 32'd0);
      chk("R13 held off launch", 32'(launch), 32'd0);
    end
    cmp_flag = 1'b1;
    @(negedge clk);
    cmp_flag = 1'b0;
    chk("R10 first done", 32'(done_ack), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R13 waiting request launched", 32'(launch), 32'd1);
    chk("R2 R3 rndout word", prim_word, 32'hCC00_0005);
    chk("R6 rndout len", 32'(data_len), 32'd2048);
    chk("R9 rndout sec", sec_word, 32'h2800_01E0);
    finish_cmp("rndout");
  endtask

  task automatic t_timeout();
    issue(8'h90, 1'b1, 16'h0, 1'b0, 24'h0, 1'b0, 1'b0);
    us_tick = 1'b1;
    for (int k = 0; k < LIMIT - 1; k++) @(negedge clk);
    chk("R11 still waiting", 32'(busy), 32'd1);
    @(negedge clk);
    us_tick = 1'b0;
    chk("R11 expired", 32'(timeout), 32'd1);
    chk("R11 ack on expiry", 32'(done_ack), 32'd1);
    chk("R12 restore on expiry", sec_word, BASE);
    @(negedge clk);
    chk("R11 sticky", 32'(timeout), 32'd1);
    issue(8'h70, 1'b0, 16'h0, 1'b0, 24'h0, 1'b0, 1'b0);
    chk("R11 cleared by request", 32'(timeout), 32'd0);
    finish_cmp("after-timeout");
  endtask

  task automatic t_orphan();
    issue(8'hD0, 1'b0, 16'h0, 1'b0, 24'h0, 1'b0, 1'b0);
    chk("R14 orphan launch", 32'(launch), 32'd1);
    chk("R14 orphan word", prim_word, 32'h8000_00D0);
    chk("R14 orphan sec", sec_word, 32'h0);
    finish_cmp("orphan");
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_opcode = 8'h0; req_has_col = 1'b0;
    req_col = '0; req_has_page = 1'b0; req_page = '0; req_cs = 1'b0; req_ecc_gen = 1'b0;
    cfg_ctl2 = BASE; cfg_use_dma = 1'b0; us_tick = 1'b0; cmp_flag = 1'b0; dma_flag = 1'b0;
    large_geom();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readid();
    t_status_dma();
    t_read0_large();
    t_readoob_large();
    t_small_page();
    t_erase_pair();
    t_program_pair();
    t_backpressure();
    t_timeout();
    t_orphan();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 50000);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog R13 actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule